// File: doc/BRIEF.md
# Dual-Mode ADC Readout Router

This block sits between an ADC sampling front end and the FIFO that feeds a USB link. A single register bit picks one of two ways of moving samples. In burst mode a start pulse opens a capture window that lasts a programmable number of clock cycles. Every valid sample in that window is stored in an on-chip capture buffer. Nothing reaches the output until the window has closed. The buffer is then emptied into the output FIFO in capture order, and the block signals completion. In streaming mode the capture buffer is bypassed and each valid sample is written straight into the output FIFO, so readout never pauses. A stop bit holds streaming off.

Both the data path and the sampling-control signals follow the mode: the buffer write enable, the buffer read enable and the output write enable are each driven only by the path that owns them. A mode change is taken only while no capture or drain is running. A built-in test source can replace the ADC data in either mode. It is a ramp that counts valid samples. The output FIFO reports a full flag. A write is committed only in a cycle where that flag is low, and it reaches the port one cycle later from the streaming path or two cycles later from the buffer. The downstream FIFO must therefore keep two words of headroom behind its full flag.

Top module: `adc_readout_router`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge: `fifo_we`, `stream_on`, `busy`, `done` and `overflow`.
- R2: In streaming mode (`stream_on`=1) a sample with `smp_valid`=1, `stop_req`=0 and `fifo_full`=0 at edge t appears on `fifo_wdata` with `fifo_we`=1 in the cycle after t. Samples keep their arrival order.
- R3: In streaming mode a valid sample that meets `fifo_full`=1 while `stop_req`=0 is dropped, and `overflow` is 1 from the next cycle. `overflow` stays 1 until an edge with `stop_req`=1, which clears it in the next cycle.
- R4: While `stop_req`=1 in streaming mode, no sample is written to the output.
- R5: In burst mode, a `start` pulse while `busy`=0 raises `busy` in the next cycle. The capture window is the next min(`cap_len`, DEPTH) clock edges. Valid samples at those edges are stored, and valid samples outside the window are not.
- R6: No output write happens during the capture window.
- R7: After the window, the stored samples are written to the output in capture order (buffer address 0 upward), each exactly once. A buffer word is read only at an edge with `fifo_full`=0, and it appears on the port two cycles later. While `fifo_full` stays high, output writes stop within two cycles.
- R8: `done` rises, with `busy` falling at the same edge, only after the last drain write has been on the port. It stays high until the next accepted `start`. A window that stores nothing gives `done` with no output write.
- R9: `stream_on` takes the value of `stream_sel` at each edge where `busy`=0 and no burst is launched. While `busy`=1 it keeps its value, so `stream_on`=1 never occurs together with `busy`=1.
- R10: With `test_sel`=1, the data taken in either mode is the number of valid samples seen since reset before this one, modulo 2^DATA_W, instead of `smp_data`.
- R11: `start` is ignored while `busy`=1 or `stream_on`=1: no new window opens and the running window is not extended.
- R12: A `cap_len` larger than DEPTH gives a window of exactly DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe from the sampling front end |
| smp_data | input | DATA_W | ADC sample word |
| test_sel | input | 1 | Replace ADC data with the counting ramp |
| stream_sel | input | 1 | Requested mode: 1 streaming, 0 burst |
| stop_req | input | 1 | Stop bit: holds streaming off and clears overflow |
| start | input | 1 | Burst capture launch pulse |
| cap_len | input | LEN_W | Capture window length in clock cycles |
| fifo_full | input | 1 | Output FIFO has no room for a new commitment |
| fifo_we | output | 1 | Output FIFO write strobe |
| fifo_wdata | output | DATA_W | Output FIFO write data |
| stream_on | output | 1 | Effective mode, 1 when streaming |
| busy | output | 1 | Capture or drain in progress |
| done | output | 1 | Last burst fully drained, held until next start |
| overflow | output | 1 | Sticky: a streamed sample was dropped |

## Verification
The assertions check the rules that can be seen cycle by cycle:
- streaming forwarding and its one-cycle latency;
- the set, hold and clear of the overflow flag, and the stop bit blocking writes;
- silence during capture;
- every drain write tracing back to a cycle with room in the FIFO;
- `done` only while idle, and the mode staying frozen while busy.

Data content needs the bench's reference queues: capture order, exactly-once draining, the window edges, the clamp of long windows, the ignored mid-window start and the ramp values. The bench compares the whole written stream against the samples it predicted, under random full-flag back-pressure and a long directed stall.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CAPT  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_src_select.sv
// Sample source: ADC word or a ramp that counts valid strobes.
module adc_src_select #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              test_sel,
  output logic [DATA_W-1:0] src_data
);
  logic [DATA_W-1:0] ramp_q;

  always_ff @(posedge clk) begin
    if (rst)            ramp_q <= '0;
    else if (smp_valid) ramp_q <= ramp_q + 1'b1;
  end

  assign src_data = test_sel ? ramp_q : smp_data;
endmodule

// File: rtl/adc_cap_ram.sv
// Simple dual-port capture buffer with a registered read, written for block RAM inference.
module adc_cap_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_burst_seq.sv
// Burst sequencer: timed capture window, then an in-order drain paced by the FIFO full flag.
module adc_burst_seq
  import adc_rd_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [LEN_W-1:0]  cap_len,
  input  logic              smp_valid,
  input  logic              fifo_full,
  output phase_t            phase,
  output logic              capturing,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              rd_valid,
  output logic              done
);
  logic [LEN_W-1:0] win_cnt;   // cycles left in the window
  logic [LEN_W-1:0] wcnt;      // samples stored
  logic [LEN_W-1:0] rcnt;      // words read back
  logic [LEN_W-1:0] len_eff;
  logic             issue;

  assign len_eff   = (cap_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cap_len;
  assign capturing = (phase == PH_CAPT);
  assign issue     = (phase == PH_DRAIN) && !fifo_full && (rcnt != wcnt);
  assign ram_we    = capturing && smp_valid;
  assign ram_waddr = wcnt[ADDR_W-1:0];
  assign ram_re    = issue;
  assign ram_raddr = rcnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      win_cnt  <= '0;
      wcnt     <= '0;
      rcnt     <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= issue;
      unique case (phase)
        PH_IDLE: begin
          if (launch) begin
            done    <= 1'b0;
            wcnt    <= '0;
            rcnt    <= '0;
            win_cnt <= len_eff;
            phase   <= (len_eff == '0) ? PH_DRAIN : PH_CAPT;
          end
        end
        PH_CAPT: begin
          if (smp_valid) wcnt <= wcnt + 1'b1;
          win_cnt <= win_cnt - 1'b1;
          if (win_cnt == LEN_W'(1)) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (issue) begin
            rcnt <= rcnt + 1'b1;
          end else if ((rcnt == wcnt) && !rd_valid) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_router.sv
// Top: mode register, streaming bypass, overflow flag and the registered output stage.
module adc_readout_router
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              test_sel,
  input  logic              stream_sel,
  input  logic              stop_req,
  input  logic              start,
  input  logic [LEN_W-1:0]  cap_len,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              stream_on,
  output logic              busy,
  output logic              done,
  output logic              overflow
);
  phase_t            phase;
  logic              in_capture;
  logic [DATA_W-1:0] src_data;
  logic              ram_we, ram_re, rd_valid;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic              idle, launch, stream_fire, stream_drop;

  assign idle        = (phase == PH_IDLE);
  assign launch      = start && idle && !stream_on;
  assign stream_fire = stream_on && smp_valid && !stop_req && !fifo_full;
  assign stream_drop = stream_on && smp_valid && !stop_req && fifo_full;
  assign busy        = !idle;

  adc_src_select #(.DATA_W(DATA_W)) u_src (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .test_sel(test_sel), .src_data(src_data)
  );

  adc_burst_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .cap_len(cap_len),
    .smp_valid(smp_valid), .fifo_full(fifo_full), .phase(phase),
    .capturing(in_capture), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .rd_valid(rd_valid), .done(done)
  );

  adc_cap_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(src_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  // Mode is sampled only while idle and not launching.
  always_ff @(posedge clk) begin
    if (rst)                 stream_on <= 1'b0;
    else if (idle && !launch) stream_on <= stream_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)              overflow <= 1'b0;
    else if (stop_req)    overflow <= 1'b0;
    else if (stream_drop) overflow <= 1'b1;
  end

  // Output stage: drain data and streamed data never overlap (mode frozen while busy).
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_we <= rd_valid || stream_fire;
      if (rd_valid)         fifo_wdata <= ram_rdata;
      else if (stream_fire) fifo_wdata <= src_data;
    end
  end
endmodule

// File: rtl/adc_readout_router_chk.sv
module adc_readout_router_chk (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic stop_req,
  input logic fifo_full,
  input logic fifo_we,
  input logic overflow,
  input logic busy,
  input logic done,
  input logic stream_on,
  input logic capturing
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!fifo_we && !busy && !done && !overflow && !stream_on));

  assert_stream_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    (stream_on && smp_valid && !stop_req && !fifo_full) |=> fifo_we);

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    (stream_on && smp_valid && !stop_req && fifo_full) |=> overflow);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (overflow && !stop_req) |=> overflow);

  assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !overflow);

  assert_stop_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (stream_on && stop_req) |=> !fifo_we);

  assert_capture_silent_R6: assert property (@(posedge clk) disable iff (rst)
    capturing |-> !fifo_we);

  assert_drain_room_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && fifo_we) |-> $past(!fifo_full, 2));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (stream_on == $past(stream_on)));

  assert_mode_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    stream_on |-> !busy);
endmodule

bind adc_readout_router adc_readout_router_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .stop_req(stop_req),
  .fifo_full(fifo_full), .fifo_we(fifo_we), .overflow(overflow),
  .busy(busy), .done(done), .stream_on(stream_on), .capturing(in_capture)
);

// File: tb/test_adc_readout_router.sv
module test_adc_readout_router;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 32;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          smp_valid, test_sel, stream_sel, stop_req, start, fifo_full;
  logic [DW-1:0] smp_data;
  logic [LW-1:0] cap_len;
  logic          fifo_we, stream_on, busy, done, overflow;
  logic [DW-1:0] fifo_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_readout_router #(.DATA_W(DW), .DEPTH(DEPTH)) i_adc_readout_router (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .test_sel(test_sel), .stream_sel(stream_sel), .stop_req(stop_req),
    .start(start), .cap_len(cap_len), .fifo_full(fifo_full),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .stream_on(stream_on),
    .busy(busy), .done(done), .overflow(overflow)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] got_q[$];
  logic [DW-1:0] ramp_m = '0;
  bit          ovf_m = 0;
  bit          in_stream = 0;
  bit          in_window = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Output monitor, sampled shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && fifo_we) got_q.push_back(fifo_wdata);
  end

  function automatic logic [DW-1:0] pick(logic [DW-1:0] d);
    return test_sel ? ramp_m : d;
  endfunction

  // One cycle: drive at the falling edge, predict, wait for the next falling edge.
  task automatic step(bit v, logic [DW-1:0] d, bit f, bit s, bit go);
    logic [DW-1:0] cur;
    smp_valid = v; smp_data = d; fifo_full = f; stop_req = s; start = go;
    cur = pick(d);
    if (v) ramp_m = ramp_m + 1'b1;
    if (in_stream && v && !s && !f) exp_q.push_back(cur);
    if (in_window && v) exp_q.push_back(cur);
    if (s) ovf_m = 0;
    else if (in_stream && v && f) ovf_m = 1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  task automatic compare(string tag);
    chk(got_q.size() == exp_q.size(), {tag, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " word value"}, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic stream_run(int n, int vpct, int fpct, int spct);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 100) < vpct, DW'($urandom), ($urandom % 100) < fpct,
           ($urandom % 100) < spct, 0);
      chk(overflow == ovf_m, "R3 overflow flag", overflow, ovf_m);
    end
  endtask

  // eff: expected window length; stall: hold full high in the drain.
  task automatic burst(int len, int eff, int fpct, bit allv, bit stall,
                       bit midmode, bit midstart, string tag);
    int g0;
    int cnt;
    cap_len = LW'(len);
    step(0, '0, 0, 0, 1);
    chk(busy == 1'b1, {"R5 busy after start ", tag}, busy, 1);
    chk(done == 1'b0, {"R8 done cleared ", tag}, done, 0);
    in_window = 1;
    for (int i = 0; i < eff; i++) begin
      if (midmode && i == 2) stream_sel = 1'b1;
      step(allv ? 1'b1 : (($urandom % 100) < 70), DW'($urandom),
           ($urandom % 2) == 0, 0, midstart && (i == 4));
    end
    in_window = 0;
    chk(got_q.size() == 0, {"R6 silent during capture ", tag}, got_q.size(), 0);
    if (midmode) chk(stream_on == 1'b0, "R9 mode frozen while busy", stream_on, 0);
    if (stall) begin
      for (int i = 0; i < 12; i++) begin
        step(1, DW'($urandom), 1, 0, 0);
        if (i == 2) g0 = got_q.size();
      end
      chk(got_q.size() == g0, "R7 no writes while full held", got_q.size(), g0);
      chk(busy == 1'b1, "R7 drain waits on full", busy, 1);
    end
    cnt = 0;
    while (!done && cnt < 500) begin
      step(($urandom % 100) < 50, DW'($urandom), ($urandom % 100) < fpct, 0, 0);
      cnt++;
    end
    chk(done == 1'b1, {"R8 done reached ", tag}, done, 1);
    chk(busy == 1'b0, {"R8 busy low with done ", tag}, busy, 0);
    compare({"R7 drain ", tag});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst = 1; smp_valid = 0; smp_data = '0; test_sel = 0; stream_sel = 0;
    stop_req = 0; start = 0; cap_len = '0; fifo_full = 0;
    repeat (4) @(negedge clk);
    chk(fifo_we == 0,   "R1 fifo_we reset", fifo_we, 0);
    chk(stream_on == 0, "R1 stream_on reset", stream_on, 0);
    chk(busy == 0,      "R1 busy reset", busy, 0);
    chk(done == 0,      "R1 done reset", done, 0);
    chk(overflow == 0,  "R1 overflow reset", overflow, 0);
    rst = 0;
    idle(2);

    // Streaming, ADC data
    stream_sel = 1; idle(2);
    chk(stream_on == 1, "R9 enter streaming", stream_on, 1);
    in_stream = 1;
    stream_run(300, 70, 25, 5);
    // R4: stop held, samples offered with room
    for (int i = 0; i < 10; i++) step(1, DW'($urandom), 0, 1, 0);
    idle(3);
    compare("R2 R4 stream");
    // R10: test ramp while streaming
    test_sel = 1;
    stream_run(150, 80, 20, 0);
    idle(3);
    compare("R10 stream ramp");
    test_sel = 0;
    // R11: start ignored in streaming mode
    step(0, '0, 0, 0, 1);
    chk(busy == 0, "R11 start ignored when streaming", busy, 0);
    step(0, '0, 0, 1, 0);
    in_stream = 0;
    stream_sel = 0; idle(3);
    chk(stream_on == 0, "R9 leave streaming", stream_on, 0);
    compare("R2 stream tail");

    // Bursts
    burst(20, 20, 30, 0, 0, 0, 0, "random");
    idle(2);
    chk(done == 1, "R8 done held while idle", done, 1);
    burst(20, 20, 10, 1, 1, 0, 0, "stall");
    burst(0, 0, 0, 0, 0, 0, 0, "empty");
    burst(50, DEPTH, 20, 1, 0, 0, 0, "R12 clamp");
    burst(12, 12, 30, 0, 0, 0, 1, "R11 mid start");
    test_sel = 1;
    burst(16, 16, 25, 0, 0, 0, 0, "R10 ramp");
    test_sel = 0;
    burst(10, 10, 20, 1, 0, 1, 0, "mode change");
    step(0, '0, 0, 0, 0);
    chk(stream_on == 1, "R9 mode taken after done", stream_on, 1);
    step(0, '0, 0, 1, 0);
    stream_sel = 0; idle(2);
    burst(DEPTH, DEPTH, 40, 0, 0, 0, 0, "full depth");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule